// File: doc/BRIEF.md
# Overcurrent Pulse-Skip Latch

This block handles overcurrent events in a switching buck regulator, one switching cycle at a time. A one-clock strobe marks the start of every switching cycle. On that strobe the block samples a current-limit flag produced by low-side current sensing. When the flag is found set while the block is idle, a new episode begins. The high-side drive is held off for a run of skip cycles. A watch window of equal default length follows, in which high-side pulses run normally.

A further current-limit detection inside the watch window escalates to a protection latch. The latch keeps the high-side drive off and the chip disabled. If the watch window passes without a detection, the block drops back to idle and is ready for the next episode. Only a supply-level reset (the synchronous reset input) or pulling the enable low releases the latch.

The outputs are registered from the episode state. Each output therefore changes on the clock edge that samples the cycle-start strobe. An episode always counts switching cycles (strobes), never clock periods.

Top module: `ocp_skip_latch`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three outputs are 0 after that edge.
- R2: A cycle-start strobe with `ilim_flag`=1, while the block is idle and enabled, sets `hs_inhibit`=1 and `busy`=1 from the next clock edge. That strobe is cycle 1 of the episode.
- R3: `hs_inhibit` stays 1 through cycles 1 to 8 (default SKIP_CYCLES). It drops to 0 on the edge that samples the strobe of cycle 9.
- R4: `ilim_flag` values sampled at the strobes of cycles 2 to 8 have no effect. They neither set the latch nor lengthen the skip run.
- R5: `ilim_flag`=1 at the strobe of any cycle from 9 to 16 sets `prot_latched`=1 and `hs_inhibit`=1, and clears `busy`, from the next edge. Cycles 9 and 16 are included.
- R6: During cycles 9 to 16, `hs_inhibit`=0 and `busy`=1. With no detection in that window, the strobe of cycle 17 returns the block to idle, with all outputs 0.
- R7: `ilim_flag`=1 at the strobe of cycle 17 starts a new episode (R2 behaviour) rather than latching.
- R8: Once set, `prot_latched` holds regardless of strobes and flag. It clears, together with the other outputs, on the first edge where `en`=0.
- R9: `ilim_flag` is sampled only on clocks where `cyc_start`=1. With `cyc_start`=0 the outputs do not change, and clocks without a strobe do not advance the episode.
- R10: While `en`=0, strobes with `ilim_flag`=1 start no episode, and all outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset, driven from supply undervoltage |
| en | input | 1 | Chip enable; low clears all state including the latch |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| ilim_flag | input | 1 | Current-limit detect from low-side sensing |
| hs_inhibit | output | 1 | 1 blocks the high-side drive pulse |
| prot_latched | output | 1 | Protection latch set; chip disabled |
| busy | output | 1 | Skip or watch window in progress |

## Verification
Two functions can fall on the same strobe: the expiry of the watch window and a new detection. At the cycle-17 strobe, the end-of-episode return to idle competes with the start of a fresh episode. At the cycle-9 strobe, the end of skipping competes with escalation to the latch. The bench provokes both by raising `ilim_flag` exactly on those strobes. It judges the outcome at the next falling edge. Cycle 17 must give inhibit and busy with no latch. Cycle 9 must give the latch with busy cleared.

// File: rtl/ocp_pkg.sv
// Package: shared state encoding for the overcurrent pulse-skip latch.
// Assumes: one controller, one clock domain.
package ocp_pkg;
    typedef enum logic [1:0] {
        OC_IDLE  = 2'd0,
        OC_SKIP  = 2'd1,
        OC_WATCH = 2'd2,
        OC_LATCH = 2'd3
    } oc_state_e;
endpackage

// File: rtl/ocp_cycle_counter.sv
// Module: switching-cycle counter for one overcurrent episode.
// Counts cycle-start strobes; clear has priority over load-to-one,
// which has priority over advance. Assumes synchronous active-low reset.
module ocp_cycle_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load_one,
    input  logic             adv,
    output logic [CNT_W-1:0] cnt
);
    // Hold, clear, load or advance the episode cycle number.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (load_one) begin
            cnt <= CNT_W'(1);
        end else if (adv) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ocp_ctrl_fsm.sv
// Module: episode controller. On each strobe it decides between idle,
// skipping, watching and latched, based on the flag and the cycle
// number held by the counter. Assumes cnt is the number of the cycle
// whose strobe was last taken in the current episode.
module ocp_ctrl_fsm
    import ocp_pkg::*;
#(
    parameter int SKIP_CYCLES  = 8,
    parameter int WATCH_CYCLES = 8,
    parameter int CNT_W        = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cyc_start,
    input  logic             ilim_flag,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             cnt_load,
    output logic             cnt_adv,
    output oc_state_e        state
);
    localparam logic [CNT_W-1:0] LAST_SKIP  = CNT_W'(SKIP_CYCLES);
    localparam logic [CNT_W-1:0] LAST_WATCH = CNT_W'(SKIP_CYCLES + WATCH_CYCLES);

    oc_state_e nxt;

    // Next-state and counter-control decision, taken only on strobes.
    always_comb begin
        nxt      = state;
        cnt_clr  = 1'b0;
        cnt_load = 1'b0;
        cnt_adv  = 1'b0;
        if (!en) begin
            nxt     = OC_IDLE;
            cnt_clr = 1'b1;
        end else if (cyc_start) begin
            unique case (state)
                OC_IDLE: begin
                    if (ilim_flag) begin
                        nxt      = OC_SKIP;
                        cnt_load = 1'b1;
                    end
                end
                OC_SKIP: begin
                    if (cnt == LAST_SKIP && ilim_flag) begin
                        nxt     = OC_LATCH;
                        cnt_clr = 1'b1;
                    end else begin
                        if (cnt == LAST_SKIP) nxt = OC_WATCH;
                        cnt_adv = 1'b1;
                    end
                end
                OC_WATCH: begin
                    if (cnt == LAST_WATCH) begin
                        if (ilim_flag) begin
                            nxt      = OC_SKIP;
                            cnt_load = 1'b1;
                        end else begin
                            nxt     = OC_IDLE;
                            cnt_clr = 1'b1;
                        end
                    end else if (ilim_flag) begin
                        nxt     = OC_LATCH;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_adv = 1'b1;
                    end
                end
                OC_LATCH: nxt = OC_LATCH;
                default:  nxt = OC_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= OC_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/ocp_skip_latch.sv
// Module: top of the overcurrent pulse-skip latch. Ties the counter
// and the controller together and decodes the registered state into
// the drive inhibit, latch and busy outputs.
// Assumes cyc_start is one clock wide per switching cycle.
module ocp_skip_latch
    import ocp_pkg::*;
#(
    parameter int SKIP_CYCLES  = 8,
    parameter int WATCH_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic cyc_start,
    input  logic ilim_flag,
    output logic hs_inhibit,
    output logic prot_latched,
    output logic busy
);
    localparam int CNT_W = $clog2(SKIP_CYCLES + WATCH_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             cnt_load;
    logic             cnt_adv;
    oc_state_e        state;

    ocp_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .load_one (cnt_load),
        .adv      (cnt_adv),
        .cnt      (cnt)
    );

    ocp_ctrl_fsm #(
        .SKIP_CYCLES  (SKIP_CYCLES),
        .WATCH_CYCLES (WATCH_CYCLES),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cyc_start (cyc_start),
        .ilim_flag (ilim_flag),
        .cnt       (cnt),
        .cnt_clr   (cnt_clr),
        .cnt_load  (cnt_load),
        .cnt_adv   (cnt_adv),
        .state     (state)
    );

    // Output decode from the registered state.
    always_comb begin
        hs_inhibit   = (state == OC_SKIP) || (state == OC_LATCH);
        prot_latched = (state == OC_LATCH);
        busy         = (state == OC_SKIP) || (state == OC_WATCH);
    end
endmodule

// File: rtl/ocp_skip_latch_chk.sv
// Module: property checker for the overcurrent pulse-skip latch,
// observing the top-level ports only. Bound to the top below.
module ocp_skip_latch_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic cyc_start,
    input logic ilim_flag,
    input logic hs_inhibit,
    input logic prot_latched,
    input logic busy
);
    // R2: detection while idle starts the skip run.
    p_start_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !prot_latched && en && cyc_start && ilim_flag) |=> (hs_inhibit && busy));

    // R9: no strobe, no change.
    p_no_strobe_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !cyc_start) |=> ($stable(hs_inhibit) && $stable(prot_latched) && $stable(busy)));

    // R8: the latch holds while enabled.
    p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_latched && en) |=> prot_latched);

    // R8, R10: enable low clears everything.
    p_en_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!prot_latched && !busy && !hs_inhibit));

    // R5: a latched chip keeps the high side off and is not busy.
    p_latch_inhibit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prot_latched |-> (hs_inhibit && !busy));

    // R6: leaving the skip run without latching enters the watch window.
    p_skip_to_watch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $fell(hs_inhibit)) |-> (busy && !prot_latched));
endmodule

bind ocp_skip_latch ocp_skip_latch_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .cyc_start    (cyc_start),
    .ilim_flag    (ilim_flag),
    .hs_inhibit   (hs_inhibit),
    .prot_latched (prot_latched),
    .busy         (busy)
);

// File: tb/tb_ocp_skip_latch.sv
module tb_ocp_skip_latch;
    localparam int CLK_PERIOD = 10;
    localparam int NROWS = 18;

    // Row: {en, strobe, flag, exp_inh, exp_lat, exp_busy, reps[5:0], req[3:0]}
    localparam logic [15:0] VEC [NROWS] = '{
        {3'b101, 3'b000, 6'd3, 4'd9},  // R9 flag without strobe
        {3'b111, 3'b101, 6'd1, 4'd2},  // R2 start, cycle 1
        {3'b111, 3'b101, 6'd7, 4'd4},  // R4 cycles 2..8 flag ignored
        {3'b110, 3'b001, 6'd1, 4'd3},  // R3 cycle 9 releases inhibit
        {3'b110, 3'b001, 6'd7, 4'd6},  // R6 cycles 10..16 watch
        {3'b110, 3'b000, 6'd1, 4'd6},  // R6 cycle 17 back to idle
        {3'b111, 3'b101, 6'd1, 4'd2},  // R2 second episode
        {3'b110, 3'b101, 6'd7, 4'd3},  // R3 cycles 2..8
        {3'b110, 3'b001, 6'd3, 4'd6},  // R6 cycles 9..11
        {3'b111, 3'b110, 6'd1, 4'd5},  // R5 cycle 12 latches
        {3'b110, 3'b110, 6'd4, 4'd8},  // R8 latch holds
        {3'b111, 3'b110, 6'd2, 4'd8},  // R8 latch holds with flag
        {3'b000, 3'b000, 6'd1, 4'd8},  // R8 en low clears
        {3'b011, 3'b000, 6'd3, 4'd10}, // R10 disabled
        {3'b111, 3'b101, 6'd1, 4'd2},  // R2
        {3'b110, 3'b101, 6'd7, 4'd3},  // R3
        {3'b111, 3'b110, 6'd1, 4'd5},  // R5 boundary at cycle 9
        {3'b000, 3'b000, 6'd1, 4'd8}   // R8 release
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic cyc_start = 1'b0;
    logic ilim_flag = 1'b0;
    logic hs_inhibit, prot_latched, busy;
    int n_checks = 0;
    int n_fail = 0;

    ocp_skip_latch dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .cyc_start    (cyc_start),
        .ilim_flag    (ilim_flag),
        .hs_inhibit   (hs_inhibit),
        .prot_latched (prot_latched),
        .busy         (busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic ei, el, eb, input string tag);
        n_checks++;
        if ({hs_inhibit, prot_latched, busy} !== {ei, el, eb}) begin
            n_fail++;
            $display("FAIL %s: got inh/lat/busy=%0b%0b%0b expected %0b%0b%0b",
                     tag, hs_inhibit, prot_latched, busy, ei, el, eb);
        end
    endtask

    // Drive after a falling edge, sample at the next falling edge.
    task automatic step(input logic e, s, f, input logic ei, el, eb, input string tag);
        en = e; cyc_start = s; ilim_flag = f;
        @(negedge clk);
        check(ei, el, eb, tag);
    endtask

    task automatic do_reset();
        rst_n = 0; en = 1; cyc_start = 1; ilim_flag = 1;
        @(negedge clk);
        check(0, 0, 0, "R1 reset");
        @(negedge clk);
        rst_n = 1; cyc_start = 0; ilim_flag = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // Table walk.
        for (int i = 0; i < NROWS; i++) begin
            for (int k = 0; k < int'(VEC[i][9:4]); k++) begin
                step(VEC[i][15], VEC[i][14], VEC[i][13],
                     VEC[i][12], VEC[i][11], VEC[i][10],
                     $sformatf("R%0d row %0d", VEC[i][3:0], i));
            end
        end

        // R5 boundary: flag at cycle 16 latches; then R1 reset clears it.
        step(1, 1, 1, 1, 0, 1, "R2 start");
        for (int k = 0; k < 7; k++) step(1, 1, 0, 1, 0, 1, "R3 skip");
        for (int k = 0; k < 7; k++) step(1, 1, 0, 0, 0, 1, "R6 watch 9..15");
        step(1, 1, 1, 1, 1, 0, "R5 cycle 16 latch");
        do_reset();

        // R7: flag exactly at cycle 17 starts a fresh episode.
        step(1, 1, 1, 1, 0, 1, "R2 start");
        for (int k = 0; k < 7; k++) step(1, 1, 0, 1, 0, 1, "R3 skip");
        for (int k = 0; k < 8; k++) step(1, 1, 0, 0, 0, 1, "R6 watch");
        step(1, 1, 1, 1, 0, 1, "R7 cycle 17 new episode");
        for (int k = 0; k < 7; k++) step(1, 1, 0, 1, 0, 1, "R7 new skip run");
        for (int k = 0; k < 8; k++) step(1, 1, 0, 0, 0, 1, "R7 new watch");
        step(1, 1, 0, 0, 0, 0, "R6 idle");

        // R9: clocks without strobes (flag high) neither advance nor latch.
        step(1, 1, 1, 1, 0, 1, "R2 start");
        for (int k = 0; k < 7; k++) begin
            step(1, 0, 1, 1, 0, 1, "R9 gap in skip");
            step(1, 0, 0, 1, 0, 1, "R9 gap in skip");
            step(1, 1, 0, 1, 0, 1, "R3 skip strobe");
        end
        step(1, 0, 1, 1, 0, 1, "R9 gap before cycle 9");
        step(1, 1, 0, 0, 0, 1, "R3 cycle 9");
        step(1, 0, 1, 0, 0, 1, "R9 gap in watch");
        step(1, 0, 0, 0, 1'b0, 1, "R9 gap in watch");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule